// File: doc/BRIEF.md
# Filtered Receive Message FIFO

This block is the receive store of a time-triggered bus controller. A decoder upstream reports each event on the bus. An event is a frame (header, timestamp and a stream of payload bytes) or a symbol (wakeup or collision-avoidance). The store decides whether the event is wanted. Acceptance depends on the frame identifier compared under a don't-care mask, and on a selector that chooses channels, symbols, all frames or startup frames only. Each accepted event goes into the next free slot of a circular buffer.

Software sees only the oldest unread message, through a small register window. The window holds a status word, the header, the 64-bit timestamp, and one 32-bit payload word chosen by an index register. A write to the acknowledge register drops that message and exposes the next one. An interrupt output reports either a non-empty buffer or a buffer one slot short of full. A sticky flag records that a message was lost because the buffer was full, and reading the flag clears it.

Registers use word addresses. A read returns data one clock after the read strobe. Window contents are valid from the second clock after any write, acknowledge or stored message. The bus holds at most one capture at a time, and the end strobe arrives in a cycle of its own after the last payload byte.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset the stored count is 0, the interrupt output is 0, the lost flag (bit 31 of the interrupt register, address 11) is 0, and the identifier, mask, source and interrupt-enable registers read 0.
- R2: A frame passes the identifier test when, for every bit position where the 11-bit mask (address 9) holds 0, header bits 23:13 equal the filter register (address 8). A mask bit of 1 makes that identifier bit don't-care.
- R3: The source register (address 10) uses these bits: bit0 channel A, bit1 channel B, bit2 symbols, bit3 all frames, bit4 startup frames. An event needs an enabled channel that it was seen on. A frame also needs bit3, or bit4 together with header bit 24 set. A symbol needs bit2, and the identifier test does not apply to it.
- R4: Accepted messages are read in arrival order, and the count register (address 7) gives the number stored. A write to address 6 removes the oldest message. That write is ignored when the buffer is empty, and the window then reads 0.
- R5: The status word (address 0) is: bit0 wakeup symbol, bit1 collision-avoidance symbol, bit2 frame, bit3 seen on channel A, bit4 seen on channel B, bit5 reception error reported at the end of capture.
- R6: The header word (address 1) returns the 29 captured header bits unchanged. Addresses 2 and 3 return the low and high halves of the captured timestamp.
- R7: With index N written to address 5, the payload word (address 4) holds byte 4N in bits 7:0 up to byte 4N+3 in bits 31:24. Bytes past MAX_BYTES are dropped, and unfilled lanes of the final stored word read 0.
- R8: An accepted event that arrives while DEPTH messages are stored is discarded whole and sets the lost flag. A read of address 11 returns the flag and then clears it.
- R9: Interrupt-enable bit0 drives the interrupt output while the count is non-zero, and bit1 drives it while the count is at least DEPTH-1. The output drops one clock after the enabled condition ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_start | input | 1 | Start of an event; kind, channels, header and timestamp valid |
| cap_kind | input | 2 | Event kind: 0 frame, 1 wakeup symbol, 2 collision-avoidance symbol |
| cap_ch_a | input | 1 | Event seen on channel A |
| cap_ch_b | input | 1 | Event seen on channel B |
| cap_hdr | input | 29 | Decoded header bits 28:0 |
| cap_ts | input | 64 | Timestamp of the event |
| cap_byte_vld | input | 1 | Payload byte strobe |
| cap_byte | input | 8 | Payload byte, in bus order |
| cap_end | input | 1 | End of event |
| cap_err | input | 1 | Reception error, valid with cap_end |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after bus_rd |
| irq | output | 1 | Interrupt request |

## Verification
The bench first opens the filters fully and sends frames of 3, 10 and 13 bytes on each channel. This separates correct word packing, the partial last word and truncation at the length limit from plain storage order. Identifier patterns are then chosen to differ from the filter only in masked bits, or in exactly one unmasked bit, so that a mask read with inverted polarity gives the wrong result. Source tests pair startup and non-startup frames, frames and symbols, and the two channels, each against a selector that enables only one side. Runs that fill to DEPTH-1, to DEPTH and one past it separate the two interrupt thresholds from the drop and lost-flag behaviour.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    K_FRAME = 2'd0,
    K_WAKE  = 2'd1,
    K_CAS   = 2'd2
  } rxq_kind_e;

  localparam int ID_W        = 11;
  localparam int HDR_W       = 29;
  localparam int HDR_ID_LSB  = 13;
  localparam int HDR_SU_BIT  = 24;
  localparam int SRC_W       = 5;

  // status bit positions
  localparam int ST_WAKE  = 0;
  localparam int ST_CAS   = 1;
  localparam int ST_FRAME = 2;
  localparam int ST_CHA   = 3;
  localparam int ST_CHB   = 4;
  localparam int ST_ERR   = 5;

  // register word addresses
  localparam logic [3:0] RA_STATUS  = 4'd0;
  localparam logic [3:0] RA_HDR     = 4'd1;
  localparam logic [3:0] RA_TS_LO   = 4'd2;
  localparam logic [3:0] RA_TS_HI   = 4'd3;
  localparam logic [3:0] RA_PAYLOAD = 4'd4;
  localparam logic [3:0] RA_INDEX   = 4'd5;
  localparam logic [3:0] RA_ACK     = 4'd6;
  localparam logic [3:0] RA_COUNT   = 4'd7;
  localparam logic [3:0] RA_FILT    = 4'd8;
  localparam logic [3:0] RA_MASK    = 4'd9;
  localparam logic [3:0] RA_SRC     = 4'd10;
  localparam logic [3:0] RA_IRQ     = 4'd11;

  typedef struct packed {
    logic [5:0]       status;
    logic [HDR_W-1:0] hdr;
    logic [63:0]      ts;
  } rxq_meta_t;

endpackage

// File: rtl/rxq_sdp_ram.sv
module rxq_sdp_ram #(
  parameter int W  = 32,
  parameter int D  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxq_accept.sv
module rxq_accept
  import rxq_pkg::*;
(
  input  logic [1:0]       kind,
  input  logic             ch_a,
  input  logic             ch_b,
  input  logic [ID_W-1:0]  id,
  input  logic             startup,
  input  logic [ID_W-1:0]  filt,
  input  logic [ID_W-1:0]  mask,
  input  logic [SRC_W-1:0] src,
  output logic             hit
);

  logic chan_ok, id_ok, frame_ok, is_frame, is_sym;

  always_comb begin
    is_frame = (kind == K_FRAME);
    is_sym   = (kind == K_WAKE) || (kind == K_CAS);
    chan_ok  = (src[0] && ch_a) || (src[1] && ch_b);
    id_ok    = (((id ^ filt) & ~mask) == '0);
    frame_ok = id_ok && (src[3] || (src[4] && startup));
    hit      = chan_ok && ((is_frame && frame_ok) || (is_sym && src[2]));
  end

endmodule

// File: rtl/rxq_capture.sv
module rxq_capture
  import rxq_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int PTR_W     = 2,
  parameter int WORDS     = 4,
  parameter int WIDX_W    = 2,
  parameter int AW        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       kind,
  input  logic             ch_a,
  input  logic             ch_b,
  input  logic [HDR_W-1:0] hdr,
  input  logic [63:0]      ts,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             fin,
  input  logic             err,
  input  logic             hit,
  input  logic             full,
  input  logic [PTR_W-1:0] slot,
  output logic             pl_we,
  output logic [AW-1:0]    pl_waddr,
  output logic [31:0]      pl_wdata,
  output logic             meta_we,
  output rxq_meta_t        meta_wdata,
  output logic             commit,
  output logic             drop
);

  localparam int BC_W = $clog2(MAX_BYTES + 1);

  logic              active_q, pend_q;
  logic [BC_W-1:0]   bcnt_q;
  logic [31:0]       acc_q, acc_new;
  rxq_meta_t         meta_q;
  logic [1:0]        lane;
  logic              take;
  logic [WIDX_W-1:0] widx;

  always_comb begin
    lane     = 2'(bcnt_q);
    take     = active_q && byte_vld && (bcnt_q < BC_W'(MAX_BYTES));
    acc_new  = acc_q | ({24'd0, byte_in} << (8 * lane));
    widx     = WIDX_W'(bcnt_q >> 2);
    commit   = fin && active_q;
    pl_we    = (take && lane == 2'd3) || (commit && pend_q);
    pl_wdata = take ? acc_new : acc_q;
    pl_waddr = AW'(slot) * AW'(WORDS) + AW'(widx);
    meta_we  = commit;
    meta_wdata = meta_q;
    meta_wdata.status[ST_ERR] = err;
    drop     = start && hit && full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      bcnt_q   <= '0;
      acc_q    <= '0;
      meta_q   <= '0;
    end else if (start) begin
      active_q <= hit && !full;
      pend_q   <= 1'b0;
      bcnt_q   <= '0;
      acc_q    <= '0;
      meta_q.status <= {1'b0, ch_b, ch_a, kind == K_FRAME, kind == K_CAS, kind == K_WAKE};
      meta_q.hdr    <= hdr;
      meta_q.ts     <= ts;
    end else begin
      if (take) begin
        bcnt_q <= bcnt_q + 1'b1;
        if (lane == 2'd3) begin
          acc_q  <= '0;
          pend_q <= 1'b0;
        end else begin
          acc_q  <= acc_new;
          pend_q <= 1'b1;
        end
      end
      if (commit) active_q <= 1'b0;
    end
  end

  // R7: payload writes stay inside the slot's word range
  a_r7_word_in_slot: assert property (@(posedge clk) disable iff (rst)
    pl_we |-> (int'(widx) < WORDS));

  // R8: a dropped event never leaves a capture open
  a_r8_drop_no_capture: assert property (@(posedge clk) disable iff (rst)
    drop |=> !active_q);

endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int MAX_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap_start,
  input  logic [1:0]  cap_kind,
  input  logic        cap_ch_a,
  input  logic        cap_ch_b,
  input  logic [28:0] cap_hdr,
  input  logic [63:0] cap_ts,
  input  logic        cap_byte_vld,
  input  logic [7:0]  cap_byte,
  input  logic        cap_end,
  input  logic        cap_err,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);

  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int WORDS  = (MAX_BYTES + 3) / 4;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int AW     = $clog2(DEPTH * WORDS);
  localparam int MW     = $bits(rxq_meta_t);

  logic [ID_W-1:0]   filt_q, mask_q;
  logic [SRC_W-1:0]  src_q;
  logic [1:0]        irq_en_q;
  logic              lost_q, irq_q;
  logic [WIDX_W-1:0] idx_q;
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic [31:0]       rdata_q;

  logic              hit, full, empty, ack, idx_ok;
  logic              pl_we, meta_we, commit, drop;
  logic [AW-1:0]     pl_waddr, pl_raddr;
  logic [31:0]       pl_wdata, pl_q;
  rxq_meta_t         meta_wdata, meta_q;
  logic [20:0]       unused_wdata;

  assign unused_wdata = bus_wdata[31:11];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (count_q == CNT_W'(DEPTH));
    empty    = (count_q == '0);
    ack      = bus_wr && (bus_addr == RA_ACK) && !empty;
    idx_ok   = (int'(idx_q) < WORDS);
    pl_raddr = AW'(rd_ptr_q) * AW'(WORDS) + (idx_ok ? AW'(idx_q) : '0);
  end

  rxq_accept u_accept (
    .kind    (cap_kind),
    .ch_a    (cap_ch_a),
    .ch_b    (cap_ch_b),
    .id      (cap_hdr[HDR_ID_LSB +: ID_W]),
    .startup (cap_hdr[HDR_SU_BIT]),
    .filt    (filt_q),
    .mask    (mask_q),
    .src     (src_q),
    .hit     (hit)
  );

  rxq_capture #(
    .MAX_BYTES (MAX_BYTES),
    .PTR_W     (PTR_W),
    .WORDS     (WORDS),
    .WIDX_W    (WIDX_W),
    .AW        (AW)
  ) u_capture (
    .clk        (clk),
    .rst        (rst),
    .start      (cap_start),
    .kind       (cap_kind),
    .ch_a       (cap_ch_a),
    .ch_b       (cap_ch_b),
    .hdr        (cap_hdr),
    .ts         (cap_ts),
    .byte_vld   (cap_byte_vld),
    .byte_in    (cap_byte),
    .fin        (cap_end),
    .err        (cap_err),
    .hit        (hit),
    .full       (full),
    .slot       (wr_ptr_q),
    .pl_we      (pl_we),
    .pl_waddr   (pl_waddr),
    .pl_wdata   (pl_wdata),
    .meta_we    (meta_we),
    .meta_wdata (meta_wdata),
    .commit     (commit),
    .drop       (drop)
  );

  rxq_sdp_ram #(.W(32), .D(DEPTH * WORDS), .AW(AW)) u_pl_ram (
    .clk   (clk),
    .we    (pl_we),
    .waddr (pl_waddr),
    .wdata (pl_wdata),
    .raddr (pl_raddr),
    .rdata (pl_q)
  );

  rxq_sdp_ram #(.W(MW), .D(DEPTH), .AW(PTR_W)) u_meta_ram (
    .clk   (clk),
    .we    (meta_we),
    .waddr (wr_ptr_q),
    .wdata (meta_wdata),
    .raddr (rd_ptr_q),
    .rdata (meta_q)
  );

  // pointers and occupancy
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (commit) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (ack)    rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({commit, ack})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // configuration registers and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q   <= '0;
      mask_q   <= '0;
      src_q    <= '0;
      irq_en_q <= '0;
      idx_q    <= '0;
      lost_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          RA_FILT:  filt_q   <= bus_wdata[ID_W-1:0];
          RA_MASK:  mask_q   <= bus_wdata[ID_W-1:0];
          RA_SRC:   src_q    <= bus_wdata[SRC_W-1:0];
          RA_IRQ:   irq_en_q <= bus_wdata[1:0];
          RA_INDEX: idx_q    <= WIDX_W'(bus_wdata);
          default:  ;
        endcase
      end
      if (drop)
        lost_q <= 1'b1;
      else if (bus_rd && bus_addr == RA_IRQ)
        lost_q <= 1'b0;
      irq_q <= (irq_en_q[0] && !empty) ||
               (irq_en_q[1] && (count_q >= CNT_W'(DEPTH - 1)));
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RA_STATUS:  rdata_q <= empty ? 32'd0 : 32'(meta_q.status);
        RA_HDR:     rdata_q <= empty ? 32'd0 : 32'(meta_q.hdr);
        RA_TS_LO:   rdata_q <= empty ? 32'd0 : meta_q.ts[31:0];
        RA_TS_HI:   rdata_q <= empty ? 32'd0 : meta_q.ts[63:32];
        RA_PAYLOAD: rdata_q <= (empty || !idx_ok) ? 32'd0 : pl_q;
        RA_INDEX:   rdata_q <= 32'(idx_q);
        RA_COUNT:   rdata_q <= 32'(count_q);
        RA_FILT:    rdata_q <= 32'(filt_q);
        RA_MASK:    rdata_q <= 32'(mask_q);
        RA_SRC:     rdata_q <= 32'(src_q);
        RA_IRQ:     rdata_q <= {lost_q, 29'd0, irq_en_q};
        default:    rdata_q <= 32'd0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  // R4: occupancy never exceeds the slot count
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  // R4: acknowledge on an empty buffer leaves it empty
  a_r4_ack_empty_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_ACK && empty && !commit) |=> (count_q == '0));

  // R8: a dropped event raises the lost flag
  a_r8_lost_on_drop: assert property (@(posedge clk) disable iff (rst)
    drop |=> lost_q);

  // R8: a full buffer never accepts another stored message
  a_r8_full_no_commit: assert property (@(posedge clk) disable iff (rst)
    (full && !ack) |=> (count_q == CNT_W'(DEPTH)));

  // R9: with both enables held off the interrupt stays low
  a_r9_irq_off: assert property (@(posedge clk) disable iff (rst)
    (irq_en_q == 2'b00 && $past(irq_en_q) == 2'b00) |-> !irq_q);

endmodule

// File: tb/sim_rx_msg_fifo.sv
`timescale 1ns/1ps
module sim_rx_msg_fifo;
  import rxq_pkg::*;

  localparam int DEP  = 4;
  localparam int MAXB = 10;
  localparam int NW   = (MAXB + 3) / 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_start = 0, cap_ch_a = 0, cap_ch_b = 0;
  logic [1:0]  cap_kind = 0;
  logic [28:0] cap_hdr = 0;
  logic [63:0] cap_ts = 0;
  logic        cap_byte_vld = 0, cap_end = 0, cap_err = 0;
  logic [7:0]  cap_byte = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [5:0]  st;
    logic [28:0] hdr;
    logic [63:0] ts;
    int          n;
  } exp_t;

  exp_t        sb[$];
  logic [10:0] m_filt = 0, m_mask = 0;
  logic [4:0]  m_src = 0;

  always #2.5 clk = ~clk;

  rx_msg_fifo #(.DEPTH(DEP), .MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst(rst),
    .cap_start(cap_start), .cap_kind(cap_kind), .cap_ch_a(cap_ch_a), .cap_ch_b(cap_ch_b),
    .cap_hdr(cap_hdr), .cap_ts(cap_ts), .cap_byte_vld(cap_byte_vld), .cap_byte(cap_byte),
    .cap_end(cap_end), .cap_err(cap_err),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input logic [63:0] ts, input int i);
    return 8'(ts[7:0] + 8'(i * 13));
  endfunction

  function automatic logic [28:0] mk_hdr(input logic [10:0] id, input logic su, input int cyc);
    return {4'b0000, su, id, 7'd5, 6'(cyc)};
  endfunction

  function automatic bit m_accept(input logic [1:0] k, input logic a, input logic b,
                                  input logic [28:0] h);
    bit ch, idm;
    ch = (m_src[0] && a) || (m_src[1] && b);
    if (k != 2'd0) return ch && m_src[2];
    idm = 1;
    for (int i = 0; i < 11; i++)
      if (!m_mask[i] && (h[13 + i] != m_filt[i])) idm = 0;
    return ch && idm && (m_src[3] || (m_src[4] && h[24]));
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic cfg(input logic [10:0] f, input logic [10:0] m, input logic [4:0] s);
    m_filt = f; m_mask = m; m_src = s;
    bus_write(RA_FILT, 32'(f));
    bus_write(RA_MASK, 32'(m));
    bus_write(RA_SRC, 32'(s));
  endtask

  // driver: pushes expected items and drives one capture
  task automatic send(input logic [1:0] k, input logic a, input logic b,
                      input logic [28:0] h, input logic [63:0] t, input int n, input logic e);
    exp_t x;
    if (m_accept(k, a, b, h) && sb.size() < DEP) begin
      x.st  = {e, b, a, k == 2'd0, k == 2'd2, k == 2'd1};
      x.hdr = h; x.ts = t; x.n = n;
      sb.push_back(x);
    end
    @(negedge clk);
    cap_start = 1; cap_kind = k; cap_ch_a = a; cap_ch_b = b; cap_hdr = h; cap_ts = t;
    @(negedge clk); cap_start = 0;
    for (int i = 0; i < n; i++) begin
      cap_byte_vld = 1; cap_byte = pbyte(t, i);
      @(negedge clk);
    end
    cap_byte_vld = 0; cap_end = 1; cap_err = e;
    @(negedge clk); cap_end = 0; cap_err = 0;
    @(negedge clk); @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the window
  task automatic drain();
    logic [31:0] d;
    exp_t x;
    int lim;
    bus_read(RA_COUNT, d); chk("R4 count", 64'(d), 64'(sb.size()));
    while (sb.size() > 0) begin
      x = sb.pop_front();
      bus_read(RA_STATUS, d); chk("R5 status", 64'(d), 64'(x.st));
      bus_read(RA_HDR, d);    chk("R6 header", 64'(d), 64'(x.hdr));
      bus_read(RA_TS_LO, d);  chk("R6 ts low", 64'(d), 64'(x.ts[31:0]));
      bus_read(RA_TS_HI, d);  chk("R6 ts high", 64'(d), 64'(x.ts[63:32]));
      lim = (x.n < MAXB) ? x.n : MAXB;
      for (int w = 0; w < NW; w++) begin
        logic [31:0] ew;
        if (4 * w >= lim) continue;
        ew = 0;
        for (int k = 0; k < 4; k++)
          if (4 * w + k < lim) ew[8*k +: 8] = pbyte(x.ts, 4 * w + k);
        bus_write(RA_INDEX, 32'(w));
        bus_read(RA_PAYLOAD, d); chk("R7 payload word", 64'(d), 64'(ew));
      end
      bus_write(RA_ACK, 0);
    end
    bus_read(RA_COUNT, d);  chk("R4 count after drain", 64'(d), 0);
    bus_read(RA_STATUS, d); chk("R4 empty window", 64'(d), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    bus_read(RA_COUNT, d); chk("R1 count", 64'(d), 0);
    bus_read(RA_IRQ, d);   chk("R1 irq reg", 64'(d), 0);
    bus_read(RA_SRC, d);   chk("R1 source", 64'(d), 0);
    bus_read(RA_MASK, d);  chk("R1 mask", 64'(d), 0);
    chk("R1 irq pin", 64'(irq), 0);
    bus_read(RA_STATUS, d); chk("R4 empty window at reset", 64'(d), 0);

    // R2 R5 R6 R7: open filter, varied lengths and channels
    cfg(11'h000, 11'h7FF, 5'b01011);
    send(2'd0, 1, 0, mk_hdr(11'h005, 0, 1), 64'h1111_2222_3333_4401, 3, 0);
    send(2'd0, 0, 1, mk_hdr(11'h3A7, 1, 2), 64'h0BAD_F00D_0000_0010, 10, 0);
    send(2'd0, 1, 1, mk_hdr(11'h7FF, 0, 63), 64'hFFFF_0000_1234_5620, 13, 1);
    drain();

    // R2: identifier under mask
    cfg(11'h155, 11'h00F, 5'b01011);
    send(2'd0, 1, 0, mk_hdr(11'h15A, 0, 3), 64'h30, 4, 0);
    send(2'd0, 1, 0, mk_hdr(11'h055, 0, 4), 64'h40, 4, 0);
    send(2'd0, 1, 0, mk_hdr(11'h150, 0, 5), 64'h50, 8, 0);
    send(2'd0, 1, 0, mk_hdr(11'h555, 0, 6), 64'h60, 4, 0);
    drain();

    // R3: startup-only on channel A
    cfg(11'h000, 11'h7FF, 5'b10001);
    send(2'd0, 0, 1, mk_hdr(11'h001, 1, 7), 64'h70, 2, 0);
    send(2'd0, 1, 0, mk_hdr(11'h002, 0, 8), 64'h80, 2, 0);
    send(2'd0, 1, 0, mk_hdr(11'h003, 1, 9), 64'h90, 2, 0);
    send(2'd1, 1, 0, mk_hdr(11'h000, 0, 0), 64'hA0, 0, 0);
    drain();

    // R3: symbols only on channel B, identifier test not applied
    cfg(11'h7FF, 11'h000, 5'b00110);
    send(2'd1, 0, 1, mk_hdr(11'h000, 0, 0), 64'hB0, 0, 0);
    send(2'd2, 0, 1, mk_hdr(11'h000, 0, 0), 64'hC0, 0, 0);
    send(2'd0, 0, 1, mk_hdr(11'h7FF, 1, 1), 64'hD0, 2, 0);
    send(2'd2, 1, 0, mk_hdr(11'h000, 0, 0), 64'hE0, 0, 0);
    drain();

    // R9: non-empty interrupt
    cfg(11'h000, 11'h7FF, 5'b01011);
    bus_write(RA_IRQ, 32'd1);
    chk("R9 irq idle", 64'(irq), 0);
    send(2'd0, 1, 0, mk_hdr(11'h010, 0, 1), 64'h100, 1, 0);
    chk("R9 irq non-empty", 64'(irq), 1);
    void'(sb.pop_front());
    bus_write(RA_ACK, 0);
    chk("R9 irq drops when empty", 64'(irq), 0);

    // R9: near-full interrupt
    bus_write(RA_IRQ, 32'd2);
    send(2'd0, 1, 0, mk_hdr(11'h011, 0, 1), 64'h110, 1, 0);
    send(2'd0, 1, 0, mk_hdr(11'h012, 0, 2), 64'h120, 1, 0);
    chk("R9 irq below threshold", 64'(irq), 0);
    send(2'd0, 1, 0, mk_hdr(11'h013, 0, 3), 64'h130, 1, 0);
    chk("R9 irq at depth-1", 64'(irq), 1);
    void'(sb.pop_front());
    bus_write(RA_ACK, 0);
    chk("R9 irq drops below threshold", 64'(irq), 0);
    bus_write(RA_IRQ, 32'd0);
    drain();

    // R8: overflow drops whole message, sticky flag cleared by read
    for (int i = 0; i < DEP + 1; i++)
      send(2'd0, 1, 0, mk_hdr(11'(i + 32), 0, i), 64'(256 * i + 7), 6, 0);
    bus_read(RA_COUNT, d); chk("R8 count full", 64'(d), 64'(DEP));
    bus_read(RA_IRQ, d);   chk("R8 lost flag set", 64'(d[31]), 1);
    bus_read(RA_IRQ, d);   chk("R8 lost flag cleared", 64'(d[31]), 0);
    drain();

    // R4: acknowledge on empty ignored
    bus_write(RA_ACK, 0);
    bus_read(RA_COUNT, d); chk("R4 ack on empty", 64'(d), 0);
    send(2'd0, 0, 1, mk_hdr(11'h040, 0, 4), 64'h400, 5, 0);
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule